// File: doc/BRIEF.md
# Deblocking Edge Line Filter

This block smooths one line of eight reconstructed samples that straddles a block boundary. Four samples on the near side (p0 nearest the edge, out to p3) and four on the far side (q0 nearest the edge, out to q3) enter together with the clipping bound tc, the activity threshold beta, a filter-mode code chosen by an upstream decision stage, and a flag that marks the line as chroma. One filtered line leaves per clock, one cycle later, beside a valid flag.

Luma lines are either left alone, corrected gently or smoothed strongly. The gentle correction changes at most two samples per side. The strong smoothing changes three samples per side. Chroma lines get a single-sample correction on each side. Every correction is bounded by a window derived from tc, so the block never acts as a plain FIR filter. All three filter datapaths run in parallel, and the mode code and chroma flag pick one result.

Top module: `dbf_edge_filter`

## Requirements
- R1: Mode code 0 (off) and the reserved code 3 return all eight samples unchanged.
- R2: Luma, mode code 1 (weak): delta = floor((9·(q0−p0) − 3·(q1−p1) + 8) / 16). When |delta| ≥ 10·tc the line is unchanged. Otherwise d = delta clipped to [−tc, tc], p0 becomes p0+d and q0 becomes q0−d.
- R3: In weak luma mode, when |delta| < 10·tc and |p2 − 2·p1 + p0| < (beta + (beta>>1))>>3, p1 becomes p1 + clip(floor((((p2+p0+1)>>1) − p1 + d)/2), ±(tc>>1)). q1 gets the mirror image, using −d and the q samples.
- R4: Weak luma mode never changes p2, p3, q2 or q3.
- R5: Luma, mode code 2 (strong):
  - p0 becomes (p2+2p1+2p0+2q0+q1+4)>>3.
  - p1 becomes (p2+p1+p0+q0+2)>>2.
  - p2 becomes (2p3+3p2+p1+p0+q0+4)>>3.
  - The q side mirrors these.
  - Each result is clipped to within ±2·tc of the sample it replaces.
- R6: Strong luma mode leaves p3 and q3 unchanged.
- R7: Chroma (flag 1) with mode code 1 or 2: d = clip(floor((4·(q0−p0) + p1 − q1 + 4)/8), ±tc), p0 becomes p0+d, q0 becomes q0−d, and the other six samples are unchanged.
- R8: Every output sample is saturated to 0..255.
- R9: out_valid equals in_valid of the previous cycle, and the filtered line appears exactly one cycle after capture.
- R10: In a cycle with in_valid low, the output samples keep their previous values.
- R11: The synchronous active-high reset clears out_valid and all output samples to zero.
- R12: With tc = 0, every mode leaves the line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input line is valid this cycle |
| in_chroma | input | 1 | 1 = chroma line, 0 = luma line |
| in_mode | input | 2 | 0 off, 1 weak, 2 strong, 3 reserved (off) |
| in_tc | input | 5 | Clipping bound tc |
| in_beta | input | 7 | Activity threshold beta |
| in_p | input | 32 | Near-side samples, p0 in bits 7:0 up to p3 in bits 31:24 |
| in_q | input | 32 | Far-side samples, q0 in bits 7:0 up to q3 in bits 31:24 |
| out_valid | output | 1 | Output line is valid |
| out_p | output | 32 | Filtered near-side samples, same packing as in_p |
| out_q | output | 32 | Filtered far-side samples, same packing as in_q |

## Verification
Every filtered line and its valid flag are due exactly one rising edge after the line is presented. The bench therefore changes inputs on a falling edge and compares outputs on the next falling edge, which lets it stream a new line every cycle while each comparison sits half a period clear of the capturing edge. The hold behaviour is checked on the falling edge that follows one idle cycle. The reset value is checked on the falling edge after reset is released, before any line is presented.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

    parameter int PIX_W  = 8;
    parameter int TC_W   = 5;
    parameter int BETA_W = 7;
    parameter int LINE_W = 4 * PIX_W;
    parameter int PIX_MAX = (1 << PIX_W) - 1;

    typedef logic [PIX_W-1:0] pix_t;

    typedef enum logic [1:0] {
        FM_OFF    = 2'd0,
        FM_WEAK   = 2'd1,
        FM_STRONG = 2'd2,
        FM_RSVD   = 2'd3
    } fmode_e;

    function automatic int clip3(input int lo, input int hi, input int x);
        if (x < lo) return lo;
        if (x > hi) return hi;
        return x;
    endfunction

    function automatic int iabs(input int x);
        return (x < 0) ? -x : x;
    endfunction

    function automatic pix_t to_pix(input int x);
        if (x < 0) return '0;
        if (x > PIX_MAX) return pix_t'(PIX_MAX);
        return pix_t'(x);
    endfunction

endpackage

// File: rtl/dbf_strong_side.sv
module dbf_strong_side
    import dbf_pkg::*;
(
    input  pix_t [3:0]      own_i,
    input  pix_t [1:0]      oth_i,
    input  logic [TC_W-1:0] tc_i,
    output pix_t [2:0]      new_o
);
    int s0, s1, s2, s3, o0, o1, t2;

    always_comb begin
        s0 = int'(own_i[0]);
        s1 = int'(own_i[1]);
        s2 = int'(own_i[2]);
        s3 = int'(own_i[3]);
        o0 = int'(oth_i[0]);
        o1 = int'(oth_i[1]);
        t2 = 2 * int'(tc_i);
        new_o[0] = to_pix(clip3(s0 - t2, s0 + t2, (s2 + 2*s1 + 2*s0 + 2*o0 + o1 + 4) >>> 3));
        new_o[1] = to_pix(clip3(s1 - t2, s1 + t2, (s2 + s1 + s0 + o0 + 2) >>> 2));
        new_o[2] = to_pix(clip3(s2 - t2, s2 + t2, (2*s3 + 3*s2 + s1 + s0 + o0 + 4) >>> 3));
    end
endmodule

// File: rtl/dbf_luma_weak.sv
module dbf_luma_weak
    import dbf_pkg::*;
(
    input  pix_t [2:0]        p_i,
    input  pix_t [2:0]        q_i,
    input  logic [TC_W-1:0]   tc_i,
    input  logic [BETA_W-1:0] beta_i,
    output pix_t [1:0]        p_o,
    output pix_t [1:0]        q_o
);
    int p0, p1, p2, q0, q1, q2;
    int tci, half_tc, raw, d, thr, act_p, act_q, adj_p, adj_q;

    always_comb begin
        p0 = int'(p_i[0]); p1 = int'(p_i[1]); p2 = int'(p_i[2]);
        q0 = int'(q_i[0]); q1 = int'(q_i[1]); q2 = int'(q_i[2]);
        tci     = int'(tc_i);
        half_tc = tci >>> 1;
        raw     = (9 * (q0 - p0) - 3 * (q1 - p1) + 8) >>> 4;
        d       = clip3(-tci, tci, raw);
        thr     = (int'(beta_i) + (int'(beta_i) >>> 1)) >>> 3;
        act_p   = iabs(p2 - 2*p1 + p0);
        act_q   = iabs(q2 - 2*q1 + q0);
        adj_p   = clip3(-half_tc, half_tc, ((((p2 + p0 + 1) >>> 1) - p1 + d) >>> 1));
        adj_q   = clip3(-half_tc, half_tc, ((((q2 + q0 + 1) >>> 1) - q1 - d) >>> 1));

        p_o = p_i[1:0];
        q_o = q_i[1:0];
        if (iabs(raw) < 10 * tci) begin
            p_o[0] = to_pix(p0 + d);
            q_o[0] = to_pix(q0 - d);
            if (act_p < thr) p_o[1] = to_pix(p1 + adj_p);
            if (act_q < thr) q_o[1] = to_pix(q1 + adj_q);
        end
    end
endmodule

// File: rtl/dbf_chroma.sv
module dbf_chroma
    import dbf_pkg::*;
(
    input  pix_t [1:0]      p_i,
    input  pix_t [1:0]      q_i,
    input  logic [TC_W-1:0] tc_i,
    output pix_t            p0_o,
    output pix_t            q0_o
);
    int tci, d;

    always_comb begin
        tci = int'(tc_i);
        d = clip3(-tci, tci,
                  ((((int'(q_i[0]) - int'(p_i[0])) * 4) + int'(p_i[1]) - int'(q_i[1]) + 4) >>> 3));
        p0_o = to_pix(int'(p_i[0]) + d);
        q0_o = to_pix(int'(q_i[0]) - d);
    end
endmodule

// File: rtl/dbf_edge_filter.sv
module dbf_edge_filter
    import dbf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_chroma,
    input  logic [1:0]        in_mode,
    input  logic [TC_W-1:0]   in_tc,
    input  logic [BETA_W-1:0] in_beta,
    input  logic [LINE_W-1:0] in_p,
    input  logic [LINE_W-1:0] in_q,
    output logic              out_valid,
    output logic [LINE_W-1:0] out_p,
    output logic [LINE_W-1:0] out_q
);
    pix_t [3:0] side_in [2];
    pix_t [2:0] strong_new [2];
    pix_t [1:0] weak_p, weak_q;
    pix_t       ch_p0, ch_q0;
    pix_t [3:0] nxt_p, nxt_q;
    fmode_e     mode;

    assign side_in[0] = in_p;
    assign side_in[1] = in_q;
    assign mode = fmode_e'(in_mode);

    for (genvar s = 0; s < 2; s++) begin : g_side
        dbf_strong_side u_strong (
            .own_i (side_in[s]),
            .oth_i (side_in[1-s][1:0]),
            .tc_i  (in_tc),
            .new_o (strong_new[s])
        );
    end

    dbf_luma_weak u_weak (
        .p_i    (side_in[0][2:0]),
        .q_i    (side_in[1][2:0]),
        .tc_i   (in_tc),
        .beta_i (in_beta),
        .p_o    (weak_p),
        .q_o    (weak_q)
    );

    dbf_chroma u_chroma (
        .p_i  (side_in[0][1:0]),
        .q_i  (side_in[1][1:0]),
        .tc_i (in_tc),
        .p0_o (ch_p0),
        .q0_o (ch_q0)
    );

    always_comb begin
        nxt_p = side_in[0];
        nxt_q = side_in[1];
        if (in_chroma) begin
            if (mode == FM_WEAK || mode == FM_STRONG) begin
                nxt_p[0] = ch_p0;
                nxt_q[0] = ch_q0;
            end
        end else begin
            case (mode)
                FM_WEAK: begin
                    nxt_p[1:0] = weak_p;
                    nxt_q[1:0] = weak_q;
                end
                FM_STRONG: begin
                    nxt_p[2:0] = strong_new[0];
                    nxt_q[2:0] = strong_new[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_p     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_p <= nxt_p;
                out_q <= nxt_q;
            end
        end
    end

    assert_off_passthrough_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_mode == 2'd0 || in_mode == 2'd3))
        |=> (out_p == $past(in_p) && out_q == $past(in_q)));

    assert_weak_outer_kept_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_chroma && in_mode == 2'd1)
        |=> (out_p[LINE_W-1:2*PIX_W] == $past(in_p[LINE_W-1:2*PIX_W]) &&
             out_q[LINE_W-1:2*PIX_W] == $past(in_q[LINE_W-1:2*PIX_W])));

    assert_strong_far_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_chroma && in_mode == 2'd2)
        |=> (out_p[LINE_W-1:3*PIX_W] == $past(in_p[LINE_W-1:3*PIX_W]) &&
             out_q[LINE_W-1:3*PIX_W] == $past(in_q[LINE_W-1:3*PIX_W])));

    assert_chroma_outer_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_chroma)
        |=> (out_p[LINE_W-1:PIX_W] == $past(in_p[LINE_W-1:PIX_W]) &&
             out_q[LINE_W-1:PIX_W] == $past(in_q[LINE_W-1:PIX_W])));

    assert_valid_rise_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_fall_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_p) && $stable(out_q)));

    assert_reset_clear_R11: assert property (@(posedge clk)
        rst |=> (!out_valid && out_p == '0 && out_q == '0));

    assert_zero_tc_R12: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_tc == '0)
        |=> (out_p == $past(in_p) && out_q == $past(in_q)));

endmodule

// File: tb/test_dbf_edge_filter.sv
module test_dbf_edge_filter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_chroma = 1'b0;
    logic [1:0]  in_mode = 2'd0;
    logic [4:0]  in_tc = '0;
    logic [6:0]  in_beta = '0;
    logic [31:0] in_p = '0;
    logic [31:0] in_q = '0;
    logic        out_valid;
    logic [31:0] out_p, out_q;

    int checks = 0;
    int failures = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;

    dbf_edge_filter i_dbf_edge_filter (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_chroma(in_chroma),
        .in_mode(in_mode), .in_tc(in_tc), .in_beta(in_beta),
        .in_p(in_p), .in_q(in_q),
        .out_valid(out_valid), .out_p(out_p), .out_q(out_q)
    );

    function automatic int rnd(input int m);
        seed = seed * 32'd1664525 + 32'd1013904223;
        return int'(seed[23:8]) % m;
    endfunction

    function automatic int clp(input int lo, input int hi, input int x);
        return (x < lo) ? lo : ((x > hi) ? hi : x);
    endfunction

    function automatic int mag(input int x);
        return (x < 0) ? -x : x;
    endfunction

    // reference model written from the requirements
    task automatic model(input logic [31:0] pv, input logic [31:0] qv, input int mode,
                         input int chroma, input int tc, input int beta,
                         output logic [31:0] epv, output logic [31:0] eqv);
        int p[4], q[4], rp[4], rq[4];
        int raw, d, thr, t2;
        for (int i = 0; i < 4; i++) begin
            p[i] = int'(pv[8*i +: 8]); q[i] = int'(qv[8*i +: 8]);
            rp[i] = p[i]; rq[i] = q[i];
        end
        if (mode == 1 || mode == 2) begin
            if (chroma != 0) begin
                d = clp(-tc, tc, ((q[0] - p[0]) * 4 + p[1] - q[1] + 4) >>> 3);
                rp[0] = clp(0, 255, p[0] + d);
                rq[0] = clp(0, 255, q[0] - d);
            end else if (mode == 1) begin
                raw = (9 * (q[0] - p[0]) - 3 * (q[1] - p[1]) + 8) >>> 4;
                if (mag(raw) < 10 * tc) begin
                    d = clp(-tc, tc, raw);
                    thr = (beta + (beta >>> 1)) >>> 3;
                    rp[0] = clp(0, 255, p[0] + d);
                    rq[0] = clp(0, 255, q[0] - d);
                    if (mag(p[2] - 2*p[1] + p[0]) < thr)
                        rp[1] = clp(0, 255, p[1] + clp(-(tc >>> 1), tc >>> 1,
                                   (((p[2] + p[0] + 1) >>> 1) - p[1] + d) >>> 1));
                    if (mag(q[2] - 2*q[1] + q[0]) < thr)
                        rq[1] = clp(0, 255, q[1] + clp(-(tc >>> 1), tc >>> 1,
                                   (((q[2] + q[0] + 1) >>> 1) - q[1] - d) >>> 1));
                end
            end else begin
                t2 = 2 * tc;
                rp[0] = clp(p[0]-t2, p[0]+t2, (p[2] + 2*p[1] + 2*p[0] + 2*q[0] + q[1] + 4) >>> 3);
                rp[1] = clp(p[1]-t2, p[1]+t2, (p[2] + p[1] + p[0] + q[0] + 2) >>> 2);
                rp[2] = clp(p[2]-t2, p[2]+t2, (2*p[3] + 3*p[2] + p[1] + p[0] + q[0] + 4) >>> 3);
                rq[0] = clp(q[0]-t2, q[0]+t2, (q[2] + 2*q[1] + 2*q[0] + 2*p[0] + p[1] + 4) >>> 3);
                rq[1] = clp(q[1]-t2, q[1]+t2, (q[2] + q[1] + q[0] + p[0] + 2) >>> 2);
                rq[2] = clp(q[2]-t2, q[2]+t2, (2*q[3] + 3*q[2] + q[1] + q[0] + p[0] + 4) >>> 3);
            end
        end
        for (int i = 0; i < 4; i++) begin
            epv[8*i +: 8] = 8'(clp(0, 255, rp[i]));
            eqv[8*i +: 8] = 8'(clp(0, 255, rq[i]));
        end
    endtask

    task automatic check(input string tag, input logic ev, input logic [31:0] ep,
                         input logic [31:0] eq);
        checks++;
        if (out_valid !== ev || out_p !== ep || out_q !== eq) begin
            failures++;
            $display("FAIL %s: valid=%0b p=%h q=%h expected valid=%0b p=%h q=%h",
                     tag, out_valid, out_p, out_q, ev, ep, eq);
        end
    endtask

    // drive on a falling edge, compare on the next falling edge
    task automatic run_line(input string tag, input logic [31:0] pv, input logic [31:0] qv,
                            input int mode, input int chroma, input int tc, input int beta);
        logic [31:0] ep, eq;
        model(pv, qv, mode, chroma, tc, beta, ep, eq);
        in_valid = 1'b1; in_p = pv; in_q = qv; in_mode = 2'(mode);
        in_chroma = (chroma != 0); in_tc = 5'(tc); in_beta = 7'(beta);
        @(negedge clk);
        check(tag, 1'b1, ep, eq);
    endtask

    function automatic logic [31:0] make_side(input int base, input int spread);
        logic [31:0] v;
        for (int i = 0; i < 4; i++)
            v[8*i +: 8] = 8'(clp(0, 255, base + rnd(2*spread + 1) - spread));
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int tcs[8] = '{0, 1, 2, 4, 7, 12, 25, 31};
        int betas[4] = '{0, 20, 64, 127};
        logic [31:0] pv, qv, hold_p, hold_q;
        string tag;
        int a, b;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 reset state", 1'b0, 32'h0, 32'h0);

        // R8 saturation at both ends, weak luma
        run_line("R8 high saturation", 32'hFFFF_FFFE, 32'h0000_00FF, 1, 0, 25, 127);
        run_line("R8 low saturation", 32'h0000_0001, 32'hFFFF_FF00, 1, 0, 25, 127);
        run_line("R8 chroma saturation", 32'h00FF_FFFE, 32'h0000_00FF, 1, 1, 31, 0);

        for (int mode = 0; mode < 4; mode++)
            for (int ch = 0; ch < 2; ch++)
                for (int ti = 0; ti < 8; ti++)
                    for (int bi = 0; bi < 4; bi++)
                        for (int n = 0; n < 30; n++) begin
                            case (n % 3)
                                0: begin pv = seed; void'(rnd(2)); qv = seed; void'(rnd(2)); end
                                1: begin
                                    a = rnd(256); b = clp(0, 255, a + rnd(61) - 30);
                                    pv = make_side(a, 2); qv = make_side(b, 2);
                                end
                                default: begin
                                    a = (n & 1) ? rnd(8) : 248 + rnd(8);
                                    b = clp(0, 255, a + rnd(41) - 20);
                                    pv = make_side(a, 3); qv = make_side(b, 3);
                                end
                            endcase
                            if (mode == 0 || mode == 3) tag = "R1 off or reserved";
                            else if (tcs[ti] == 0) tag = "R12 zero tc";
                            else if (ch != 0) tag = "R7 chroma";
                            else if (mode == 1) tag = "R2 R3 R4 weak luma";
                            else tag = "R5 R6 strong luma";
                            run_line(tag, pv, qv, mode, ch, tcs[ti], betas[bi]);
                        end

        // R9 and R10: an idle cycle drops valid and keeps the line
        hold_p = out_p; hold_q = out_q;
        in_valid = 1'b0; in_p = ~in_p; in_q = ~in_q; in_mode = 2'd0;
        @(negedge clk);
        check("R9 R10 idle cycle", 1'b0, hold_p, hold_q);
        run_line("R9 valid after idle", 32'h1020_3040, 32'h5060_7080, 0, 0, 3, 10);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule